// File: doc/BRIEF.md
# Programmable 32-Line Interrupt Controller

This block gathers up to 32 interrupt request lines from peripherals and reduces them to two processor-facing requests: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each source line is first brought into the local clock domain. It is then treated as a level or as an edge, in a sense that software picks for that line. A per-line enable gates the result. A per-line steering bit sends each enabled, pending source to one of the two outputs. Software reads the pending-and-enabled word and services the lowest set bit first. For edge lines it clears the event by writing a one to the matching bit of the raw register.

Each line has a two-state capture machine. `CELL_CLEAR` means no edge event is held. `CELL_LATCHED` means an edge event waits for acknowledge. The transitions are:
- **capture**: `CELL_CLEAR` to `CELL_LATCHED` on the selected edge while the line is in edge mode.
- **acknowledge**: `CELL_LATCHED` to `CELL_CLEAR` on a one written to the raw register, when no new edge arrives in the same cycle.
- **re-arm**: `CELL_LATCHED` stays latched when an edge and an acknowledge coincide.
- **drop**: either state goes to `CELL_CLEAR` whenever the line is in level mode.

The register file sits on a plain single-cycle bus. Writes take effect at the clock edge where `bus_we` is high, and reads are combinational from `bus_addr`. The byte offsets are:

| Offset | Register |
|--------|----------|
| 0x00 | enable |
| 0x04 | raw (write-one acknowledge) |
| 0x08 | status (read only) |
| 0x0C | polarity |
| 0x10 | sense type |
| 0x14 | fast-route select |

Top module: `intc_core`

## Requirements
- R1: After reset the enable, polarity, type and fast-route registers and the status register read 0, and `irq_o` and `fiq_o` are 0.
- R2: Enable (0x00), polarity (0x0C), type (0x10) and fast-route (0x14) read back what was written. Reads of any other offset, or of an offset whose two low bits are not 00, return 0. Writes to status (0x08) or to undefined offsets change no register, and no register changes on a cycle without `bus_we`.
- R3: With a type bit of 0 (level), the raw bit is 1 exactly while the synchronized line equals its polarity bit (1 = active high, 0 = active low). Acknowledge writes do not affect it.
- R4: With a type bit of 1 (edge), the raw bit is set by a rising edge when polarity is 1 and by a falling edge when polarity is 0. The opposite edge does not set it. Once set, it holds after the line returns.
- R5: Writing 1 to a raw bit of an edge line clears it. Writing 0 leaves it unchanged.
- R6: When the selected edge and an acknowledge of the same bit fall on the same clock edge, the raw bit stays set.
- R7: Status (0x08) reads raw AND enable, where an enable bit of 1 passes the source.
- R8: `irq_o` is the registered OR of status bits whose fast-route bit is 0. `fiq_o` is the registered OR of status bits whose fast-route bit is 1. Both are 0 on the cycle after status is all zero.
- R9: A level-line change driven before clock edge k reaches `irq_o` after edge k+2. An edge-line event driven before edge k reaches it after edge k+3 and not earlier.
- R10: Switching a line from edge to level discards any held edge event, so switching back shows the raw bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Asynchronous interrupt source lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Each result has a fixed due point counted from the clock edge that first sees a stimulus:
- A register write is readable right after its edge.
- A level-line raw bit is valid two edges after the line changes.
- An edge-line raw bit is valid three edges after the line changes.
- Each output request follows its status by one more edge.

The bench drives every input just after a falling edge and waits exactly that many falling edges before sampling. For both line kinds it also samples one cycle before the due point, to show the request has not arrived early. The coincident edge-and-acknowledge case is built by asserting the write strobe on the falling edge just before the capturing rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Edge-capture state of one source line
    typedef enum logic [0:0] {
        CELL_CLEAR   = 1'b0,
        CELL_LATCHED = 1'b1
    } cell_st_t;

    // Word indices of the registers (byte offset / 4)
    localparam int unsigned IDX_ENABLE = 0;
    localparam int unsigned IDX_RAW    = 1;
    localparam int unsigned IDX_STATUS = 2;
    localparam int unsigned IDX_POL    = 3;
    localparam int unsigned IDX_TYPE   = 4;
    localparam int unsigned IDX_ROUTE  = 5;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/intc_line.sv
module intc_line
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,     // synchronized source
    input  logic pol_i,      // 1: high / rising, 0: low / falling
    input  logic edge_i,     // 1: edge sensing, 0: level sensing
    input  logic ack_i,      // write-one acknowledge for this line
    output logic raw_o
);

    cell_st_t st_q, st_d;
    logic     prev_q;
    logic     rise, fall, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line_i;
    end

    assign rise = line_i & ~prev_q;
    assign fall = ~line_i & prev_q;
    assign hit  = pol_i ? rise : fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CELL_CLEAR;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CELL_CLEAR: begin
                if (edge_i && hit) st_d = CELL_LATCHED;           // capture
            end
            CELL_LATCHED: begin
                if (!edge_i)     st_d = CELL_CLEAR;               // drop
                else if (hit)    st_d = CELL_LATCHED;             // re-arm
                else if (ack_i)  st_d = CELL_CLEAR;               // acknowledge
            end
            default: st_d = CELL_CLEAR;
        endcase
    end

    // output logic
    always_comb begin
        if (edge_i) raw_o = (st_q == CELL_LATCHED);
        else        raw_o = (line_i == pol_i);
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && hit) |=> (st_q == CELL_LATCHED));

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && ack_i && !hit) |=> (st_q == CELL_CLEAR));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && st_q == CELL_LATCHED && !ack_i) |=> (st_q == CELL_LATCHED));

    // R10
    level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i) |=> (st_q == CELL_CLEAR));

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] enable_o,
    output logic [N_LINES-1:0] pol_o,
    output logic [N_LINES-1:0] type_o,
    output logic [N_LINES-1:0] route_o,
    output logic [N_LINES-1:0] ack_o,
    output logic [N_LINES-1:0] status_o
);

    localparam int unsigned IW = ADDR_W - 2;

    logic [IW-1:0]      idx;
    logic               aligned;
    logic [N_LINES-1:0] enable_q, pol_q, type_q, route_q;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            pol_q    <= '0;
            type_q   <= '0;
            route_q  <= '0;
        end else if (bus_we && aligned) begin
            if (idx == IW'(IDX_ENABLE)) enable_q <= bus_wdata;
            if (idx == IW'(IDX_POL))    pol_q    <= bus_wdata;
            if (idx == IW'(IDX_TYPE))   type_q   <= bus_wdata;
            if (idx == IW'(IDX_ROUTE))  route_q  <= bus_wdata;
        end
    end

    assign ack_o    = (bus_we && aligned && idx == IW'(IDX_RAW)) ? bus_wdata : '0;
    assign status_o = raw_i & enable_q;

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (idx == IW'(IDX_ENABLE)) bus_rdata = enable_q;
            if (idx == IW'(IDX_RAW))    bus_rdata = raw_i;
            if (idx == IW'(IDX_STATUS)) bus_rdata = status_o;
            if (idx == IW'(IDX_POL))    bus_rdata = pol_q;
            if (idx == IW'(IDX_TYPE))   bus_rdata = type_q;
            if (idx == IW'(IDX_ROUTE))  bus_rdata = route_q;
        end
    end

    assign enable_o = enable_q;
    assign pol_o    = pol_q;
    assign type_o   = type_q;
    assign route_o  = route_q;

    // R2
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we) |=> ($stable(enable_q) && $stable(pol_q) &&
                       $stable(type_q) && $stable(route_q)));

endmodule

// File: rtl/intc_route.sv
module intc_route #(
    parameter int unsigned N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] status_i,
    input  logic [N_LINES-1:0] route_i,
    output logic               irq_o,
    output logic               fiq_o
);

    logic irq_q, fiq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |(status_i & ~route_i);
            fiq_q <= |(status_i & route_i);
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;

    // R8
    irq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_i & ~route_i)) |=> irq_o);

    // R8
    fiq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_i & route_i)) |=> fiq_o);

    // R8
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i == '0) |=> (!irq_o && !fiq_o));

endmodule

// File: rtl/intc_core.sv
module intc_core #(
    parameter int unsigned N_LINES     = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] src_i,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);

    logic [N_LINES-1:0] src_sync;
    logic [N_LINES-1:0] raw, enable, pol, sense, route, ack, status;

    intc_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        intc_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (src_sync[g]),
            .pol_i  (pol[g]),
            .edge_i (sense[g]),
            .ack_i  (ack[g]),
            .raw_o  (raw[g])
        );
    end

    intc_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .raw_i     (raw),
        .enable_o  (enable),
        .pol_o     (pol),
        .type_o    (sense),
        .route_o   (route),
        .ack_o     (ack),
        .status_o  (status)
    );

    intc_route #(.N_LINES(N_LINES)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .route_i  (route),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o)
    );

    // R7
    status_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~enable) == '0) && ((status & ~raw) == '0));

endmodule

// File: tb/sim_intc_core.sv
`timescale 1ns/1ps
module sim_intc_core;

    localparam logic [7:0] A_EN   = 8'h00;
    localparam logic [7:0] A_RAW  = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_POL  = 8'h0C;
    localparam logic [7:0] A_TYPE = 8'h10;
    localparam logic [7:0] A_RTE  = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    intc_core u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check(irq_o == 1'b0, "R1 irq", {31'b0, irq_o}, 0);
        check(fiq_o == 1'b0, "R1 fiq", {31'b0, fiq_o}, 0);
        rd(A_EN, v);   check(v == 0, "R1 enable", v, 0);
        rd(A_POL, v);  check(v == 0, "R1 pol", v, 0);
        rd(A_TYPE, v); check(v == 0, "R1 type", v, 0);
        rd(A_RTE, v);  check(v == 0, "R1 route", v, 0);
        rd(A_STAT, v); check(v == 0, "R1 status", v, 0);
        // all lines level, active low, inputs low => raw all ones (R3)
        rd(A_RAW, v);  check(v == 32'hFFFF_FFFF, "R3 raw after reset", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(A_POL, 32'h1234_5678);  rd(A_POL, v);  check(v == 32'h1234_5678, "R2 pol rw", v, 32'h1234_5678);
        wr(A_TYPE, 32'h00F0_000F); rd(A_TYPE, v); check(v == 32'h00F0_000F, "R2 type rw", v, 32'h00F0_000F);
        wr(A_RTE, 32'hA5A5_0000);  rd(A_RTE, v);  check(v == 32'hA5A5_0000, "R2 route rw", v, 32'hA5A5_0000);
        wr(A_POL, 0); wr(A_TYPE, 0); wr(A_RTE, 0);
        wr(8'h18, 32'hFFFF_FFFF);  rd(8'h18, v);  check(v == 0, "R2 undefined read", v, 0);
        rd(8'h02, v); check(v == 0, "R2 misaligned read", v, 0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_EN, v);   check(v == 0, "R2 status write ignored (enable)", v, 0);
        rd(A_STAT, v); check(v == 0, "R2 status write ignored (status)", v, 0);
        rd(A_POL, v);  check(v == 0, "R2 undefined write ignored", v, 0);
    endtask

    task automatic t_level_high;
        logic [31:0] v;
        wr(A_POL, 32'h1 << 3);
        wr(A_EN, 32'h1 << 3);
        @(negedge clk); src[3] = 1'b1;
        tick(2);
        check(irq_o == 1'b0, "R9 level irq not early", {31'b0, irq_o}, 0);
        tick(1);
        check(irq_o == 1'b1, "R9 level irq due", {31'b0, irq_o}, 1);
        rd(A_RAW, v); check(v[3] == 1'b1, "R3 level high raw", v, 32'h8);
        wr(A_RAW, 32'h1 << 3);
        rd(A_RAW, v); check(v[3] == 1'b1, "R3 ack ignored on level", v, 32'h8);
        check(irq_o == 1'b1, "R3 irq still high", {31'b0, irq_o}, 1);
        src[3] = 1'b0;
        tick(3);
        check(irq_o == 1'b0, "R3 level high released", {31'b0, irq_o}, 0);
        wr(A_EN, 0); wr(A_POL, 0);
    endtask

    task automatic t_level_low;
        logic [31:0] v;
        @(negedge clk); src[5] = 1'b1;
        tick(3);
        wr(A_EN, 32'h1 << 5);
        tick(2);
        check(irq_o == 1'b0, "R3 active-low idle", {31'b0, irq_o}, 0);
        src[5] = 1'b0;
        tick(3);
        check(irq_o == 1'b1, "R3 active-low asserted", {31'b0, irq_o}, 1);
        rd(A_RAW, v); check(v[5] == 1'b1, "R3 active-low raw", v, 32'h20);
        src[5] = 1'b1;
        tick(3);
        check(irq_o == 1'b0, "R3 active-low released", {31'b0, irq_o}, 0);
        wr(A_EN, 0);
    endtask

    task automatic t_edge_rise_ack;
        logic [31:0] v;
        wr(A_TYPE, 32'h1 << 8);
        wr(A_POL, 32'h1 << 8);
        wr(A_EN, 32'h1 << 8);
        @(negedge clk); src[8] = 1'b1;
        tick(3);
        check(irq_o == 1'b0, "R9 edge irq not early", {31'b0, irq_o}, 0);
        rd(A_RAW, v); check(v[8] == 1'b1, "R4 rising latched", v, 32'h100);
        tick(1);
        check(irq_o == 1'b1, "R9 edge irq due", {31'b0, irq_o}, 1);
        src[8] = 1'b0;
        tick(4);
        rd(A_RAW, v); check(v[8] == 1'b1, "R4 latch holds", v, 32'h100);
        check(irq_o == 1'b1, "R4 irq holds", {31'b0, irq_o}, 1);
        wr(A_RAW, 32'hFFFF_FEFF);
        rd(A_RAW, v); check(v[8] == 1'b1, "R5 zero write no effect", v, 32'h100);
        wr(A_RAW, 32'h1 << 8);
        rd(A_RAW, v); check(v[8] == 1'b0, "R5 ack clears", v, 0);
        tick(1);
        check(irq_o == 1'b0, "R5 irq drops after ack", {31'b0, irq_o}, 0);
    endtask

    task automatic t_route;
        @(negedge clk); src[8] = 1'b1;
        tick(4);
        check(irq_o == 1'b1 && fiq_o == 1'b0, "R8 normal route", {30'b0, fiq_o, irq_o}, 32'h1);
        wr(A_RTE, 32'h1 << 8);
        tick(1);
        check(irq_o == 1'b0 && fiq_o == 1'b1, "R8 fast route", {30'b0, fiq_o, irq_o}, 32'h2);
        wr(A_RAW, 32'h1 << 8);
        tick(1);
        check(irq_o == 1'b0 && fiq_o == 1'b0, "R8 both quiet", {30'b0, fiq_o, irq_o}, 0);
        src[8] = 1'b0;
        tick(3);
        wr(A_RTE, 0);
    endtask

    task automatic t_edge_fall;
        logic [31:0] v;
        wr(A_TYPE, (32'h1 << 8) | (32'h1 << 9));
        wr(A_EN, 32'h1 << 9);
        @(negedge clk); src[9] = 1'b1;
        tick(4);
        rd(A_RAW, v); check(v[9] == 1'b0, "R4 rising ignored on falling line", v, 0);
        check(irq_o == 1'b0, "R4 no irq on wrong edge", {31'b0, irq_o}, 0);
        src[9] = 1'b0;
        tick(4);
        rd(A_RAW, v); check(v[9] == 1'b1, "R4 falling latched", v, 32'h200);
        check(irq_o == 1'b1, "R4 falling irq", {31'b0, irq_o}, 1);
        wr(A_RAW, 32'h1 << 9);
        tick(1);
        check(irq_o == 1'b0, "R5 falling ack", {31'b0, irq_o}, 0);
        wr(A_EN, 0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        @(negedge clk); src[8] = 1'b1;
        tick(4);
        rd(A_RAW, v); check(v[8] == 1'b1, "R6 first event latched", v, 32'h100);
        src[8] = 1'b0;
        tick(3);
        src[8] = 1'b1;
        tick(2);
        bus_we = 1'b1; bus_addr = A_RAW; bus_wdata = 32'h1 << 8;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        rd(A_RAW, v); check(v[8] == 1'b1, "R6 new edge beats ack", v, 32'h100);
        wr(A_RAW, 32'h1 << 8);
        rd(A_RAW, v); check(v[8] == 1'b0, "R5 later ack clears", v, 0);
    endtask

    task automatic t_drop;
        logic [31:0] v;
        src[8] = 1'b0;
        tick(3);
        src[8] = 1'b1;
        tick(4);
        src[8] = 1'b0;
        tick(3);
        rd(A_RAW, v); check(v[8] == 1'b1, "R10 latched before switch", v, 32'h100);
        wr(A_TYPE, 32'h1 << 9);
        wr(A_TYPE, (32'h1 << 8) | (32'h1 << 9));
        rd(A_RAW, v); check(v[8] == 1'b0, "R10 event dropped", v, 0);
    endtask

    task automatic t_status;
        logic [31:0] raw_v, st_v;
        wr(A_EN, 32'hFFFF_0000);
        rd(A_RAW, raw_v);
        rd(A_STAT, st_v);
        check(st_v == (raw_v & 32'hFFFF_0000), "R7 status is raw and enable", st_v, raw_v & 32'hFFFF_0000);
        check(st_v == 32'hFFFF_0000, "R7 upper level lines pending", st_v, 32'hFFFF_0000);
        tick(1);
        check(irq_o == 1'b1 && fiq_o == 1'b0, "R8 status drives irq", {30'b0, fiq_o, irq_o}, 32'h1);
        wr(A_EN, 0);
        rd(A_STAT, st_v); check(st_v == 0, "R7 disabled status", st_v, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_regs();
        t_level_high();
        t_level_low();
        t_edge_rise_ack();
        t_route();
        t_edge_fall();
        t_set_wins();
        t_drop();
        t_status();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule